// File: doc/BRIEF.md
# Sprite Attribute Page Copier

This block fills a 256-byte sprite attribute store from system memory. Software writes one byte, the page number, to the trigger input. The copier then reads that whole 256-byte page from a synchronous source-memory port. The read address is the page number in the high byte and a running offset in the low byte. Each returned byte goes into the attribute store at the index equal to its offset.

The source port returns data one cycle after a read strobe. Reads are pipelined, so after the first read one byte is written on every cycle. `busy` covers the whole copy, and a single-cycle `done` follows the last write.

The store holds 64 sprite records of four bytes each. Within a record the bytes are, by ascending index: vertical position, tile number, attribute flags and horizontal position. Two read ports give access to the store. One returns a single byte by index. The other returns a whole sprite record by sprite number, split into its four fields.

Top module: `oam_page_copier`

## Requirements
- R1: Synchronous active-high reset clears `busy`, `done` and `src_rd_en`, sets every byte of the store to zero, and aborts any copy in progress.
- R2: A trigger with page value P, taken while idle, makes every read of that copy present `src_addr` = {P, offset}, where P is in bits 15:8. The first read, in the cycle after the trigger edge, uses offset 0x00.
- R3: A copy issues exactly 256 read strobes on consecutive cycles, and the offsets ascend by one from 0x00 to 0xFF. No strobe occurs outside `busy`.
- R4: The byte returned for offset n, sampled one cycle after the strobe for n, is written to store index n for every n from 0 to 255.
- R5: `busy` rises in the cycle after the accepted trigger and stays high for exactly 257 cycles, until the edge that writes index 255. `done` is never high while `busy` is high.
- R6: `done` is high for exactly one cycle, the first cycle after `busy` falls.
- R7: A trigger that arrives while `busy` is high has no effect. The page in `src_addr` is unchanged, the strobe count stays 256, and the store ends with the first page's data.
- R8: For sprite number s (0 to 63), `spr_y`, `spr_tile`, `spr_attr` and `spr_x` show store bytes 4s, 4s+1, 4s+2 and 4s+3 respectively.
- R9: `rd_data` shows the store byte at index `rd_idx` combinationally.
- R10: A trigger presented in the `done` cycle is accepted, and a new copy starts with `busy` high in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_we | input | 1 | Write strobe for the page trigger |
| trig_page | input | 8 | Source page number |
| src_rd_en | output | 1 | Source read strobe |
| src_addr | output | 16 | Source read address {page, offset} |
| src_rd_data | input | 8 | Source read data, valid one cycle after the strobe |
| busy | output | 1 | Copy in progress |
| done | output | 1 | One-cycle end-of-copy pulse |
| rd_idx | input | 8 | Byte index for the byte read port |
| rd_data | output | 8 | Store byte at `rd_idx` |
| spr_sel | input | 6 | Sprite number for the record read port |
| spr_y | output | 8 | Vertical position byte of the selected sprite |
| spr_tile | output | 8 | Tile number byte of the selected sprite |
| spr_attr | output | 8 | Attribute byte of the selected sprite |
| spr_x | output | 8 | Horizontal position byte of the selected sprite |

## Verification
The source model returns a byte that depends on both the page and the offset. This lets a full comparison of the store tell apart a wrong page, a swapped or shifted offset, and a write that is off by one cycle of latency. Copies run from page 0x00, page 0xFF and several mid-range pages. Each page probes a different byte and sprite record, so every field lane of the record port is exercised. Directed cases then cover:
- a trigger injected mid-copy, which must leave both the address stream and the contents untouched;
- a trigger in the `done` cycle, which must chain straight into a new copy;
- a reset mid-copy, which must stop the strobes and clear the store.

// File: rtl/oamdma_pkg.sv
package oamdma_pkg;

    localparam int BYTE_W     = 8;
    localparam int PAGE_W     = 8;
    localparam int OFFS_W     = 8;
    localparam int SRC_ADDR_W = PAGE_W + OFFS_W;
    localparam int STORE_DEPTH = 1 << OFFS_W;
    localparam int SPR_BYTES  = 4;
    localparam int LANE_W     = $clog2(SPR_BYTES);
    localparam int SPR_COUNT  = STORE_DEPTH / SPR_BYTES;
    localparam int SPR_SEL_W  = $clog2(SPR_COUNT);

    // Byte lane order inside one sprite record; the read port decodes by it.
    localparam int LANE_Y    = 0;
    localparam int LANE_TILE = 1;
    localparam int LANE_ATTR = 2;
    localparam int LANE_X    = 3;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_COPY   = 2'd1,
        ST_FINISH = 2'd2
    } copy_state_t;

    // Write slot carried one cycle behind the read strobe.
    typedef struct packed {
        logic              vld;
        logic [OFFS_W-1:0] idx;
    } wr_slot_t;

    typedef struct packed {
        logic [BYTE_W-1:0] y;
        logic [BYTE_W-1:0] tile;
        logic [BYTE_W-1:0] attr;
        logic [BYTE_W-1:0] x;
    } sprite_rec_t;

    function automatic logic [SRC_ADDR_W-1:0] page_addr(
        input logic [PAGE_W-1:0] page,
        input logic [OFFS_W-1:0] offs
    );
        return {page, offs};
    endfunction

    function automatic logic last_offset(input logic [OFFS_W-1:0] offs);
        return &offs;
    endfunction

endpackage

// File: rtl/oam_dma_seq.sv
module oam_dma_seq
    import oamdma_pkg::*;
#(
    parameter int P_W = PAGE_W,
    parameter int O_W = OFFS_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trig_we,
    input  logic [P_W-1:0]   trig_page,
    output logic             src_rd_en,
    output logic [P_W+O_W-1:0] src_addr,
    output logic             wr_en,
    output logic [O_W-1:0]   wr_idx,
    output logic             busy,
    output logic             done
);

    copy_state_t  state_q;
    logic [P_W-1:0] page_q;
    logic [O_W:0]   issue_cnt;   // extra bit marks all reads issued
    logic           slot_vld;
    logic [O_W-1:0] slot_idx;
    logic           take_trig;
    logic           last_wr;

    assign busy      = (state_q == ST_COPY);
    assign done      = (state_q == ST_FINISH);
    assign take_trig = trig_we && !busy;
    assign src_rd_en = busy && !issue_cnt[O_W];
    assign src_addr  = {page_q, issue_cnt[O_W-1:0]};
    assign wr_en     = slot_vld;
    assign wr_idx    = slot_idx;
    assign last_wr   = slot_vld && (&slot_idx);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            page_q    <= '0;
            issue_cnt <= '0;
            slot_vld  <= 1'b0;
            slot_idx  <= '0;
        end else begin
            slot_vld <= src_rd_en;
            slot_idx <= issue_cnt[O_W-1:0];
            if (src_rd_en) begin
                issue_cnt <= issue_cnt + 1'b1;
            end
            case (state_q)
                ST_COPY: begin
                    if (last_wr) begin
                        state_q <= ST_FINISH;
                    end
                end
                default: begin
                    if (take_trig) begin
                        state_q   <= ST_COPY;
                        page_q    <= trig_page;
                        issue_cnt <= '0;
                    end else begin
                        state_q <= ST_IDLE;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/oam_attr_store.sv
module oam_attr_store
    import oamdma_pkg::*;
#(
    parameter int O_W  = OFFS_W,
    parameter int D_W  = BYTE_W,
    parameter int S_W  = SPR_SEL_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           wr_en,
    input  logic [O_W-1:0] wr_idx,
    input  logic [D_W-1:0] wr_data,
    input  logic [O_W-1:0] rd_idx,
    output logic [D_W-1:0] rd_data,
    input  logic [S_W-1:0] spr_sel,
    output logic [D_W-1:0] lane_data [SPR_BYTES]
);

    localparam int DEPTH = 1 << O_W;

    logic [D_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

    assign rd_data = mem[rd_idx];

    for (genvar b = 0; b < SPR_BYTES; b++) begin : g_lane
        localparam logic [LANE_W-1:0] LANE = LANE_W'(b);
        assign lane_data[b] = mem[{spr_sel, LANE}];
    end

endmodule

// File: rtl/oam_page_copier.sv
module oam_page_copier
    import oamdma_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  trig_we,
    input  logic [PAGE_W-1:0]     trig_page,
    output logic                  src_rd_en,
    output logic [SRC_ADDR_W-1:0] src_addr,
    input  logic [BYTE_W-1:0]     src_rd_data,
    output logic                  busy,
    output logic                  done,
    input  logic [OFFS_W-1:0]     rd_idx,
    output logic [BYTE_W-1:0]     rd_data,
    input  logic [SPR_SEL_W-1:0]  spr_sel,
    output logic [BYTE_W-1:0]     spr_y,
    output logic [BYTE_W-1:0]     spr_tile,
    output logic [BYTE_W-1:0]     spr_attr,
    output logic [BYTE_W-1:0]     spr_x
);

    logic              wr_en;
    logic [OFFS_W-1:0] wr_idx;
    logic [BYTE_W-1:0] lane_data [SPR_BYTES];
    sprite_rec_t       rec;

    oam_dma_seq #(.P_W(PAGE_W), .O_W(OFFS_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .trig_we   (trig_we),
        .trig_page (trig_page),
        .src_rd_en (src_rd_en),
        .src_addr  (src_addr),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .busy      (busy),
        .done      (done)
    );

    oam_attr_store #(.O_W(OFFS_W), .D_W(BYTE_W), .S_W(SPR_SEL_W)) u_store (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (src_rd_data),
        .rd_idx    (rd_idx),
        .rd_data   (rd_data),
        .spr_sel   (spr_sel),
        .lane_data (lane_data)
    );

    always_comb begin
        rec.y    = lane_data[LANE_Y];
        rec.tile = lane_data[LANE_TILE];
        rec.attr = lane_data[LANE_ATTR];
        rec.x    = lane_data[LANE_X];
    end

    assign spr_y    = rec.y;
    assign spr_tile = rec.tile;
    assign spr_attr = rec.attr;
    assign spr_x    = rec.x;

endmodule

// File: rtl/oam_page_copier_chk.sv
module oam_page_copier_chk (
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic        done,
    input logic        src_rd_en,
    input logic [15:0] src_addr
);

    assert_first_offset_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (src_rd_en && src_addr[7:0] == 8'h00));

    assert_strobe_in_busy_R3: assert property (@(posedge clk) disable iff (rst)
        src_rd_en |-> busy);

    assert_offset_step_R3: assert property (@(posedge clk) disable iff (rst)
        (src_rd_en && $past(src_rd_en)) |-> (src_addr == $past(src_addr) + 16'd1));

    assert_page_held_R7: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> (src_addr[15:8] == $past(src_addr[15:8])));

    assert_no_overlap_R5: assert property (@(posedge clk) disable iff (rst)
        busy |-> !done);

    assert_done_after_busy_R6: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(busy));

    assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

bind oam_page_copier oam_page_copier_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .done      (done),
    .src_rd_en (src_rd_en),
    .src_addr  (src_addr)
);

// File: tb/oam_page_copier_test.sv
`timescale 1ns/1ps
module oam_page_copier_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        trig_we = 1'b0;
    logic [7:0]  trig_page = 8'h00;
    logic        src_rd_en;
    logic [15:0] src_addr;
    logic [7:0]  src_rd_data = 8'hEE;
    logic        busy, done;
    logic [7:0]  rd_idx = 8'h00;
    logic [7:0]  rd_data;
    logic [5:0]  spr_sel = 6'd0;
    logic [7:0]  spr_y, spr_tile, spr_attr, spr_x;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    oam_page_copier uut (
        .clk(clk), .rst(rst), .trig_we(trig_we), .trig_page(trig_page),
        .src_rd_en(src_rd_en), .src_addr(src_addr), .src_rd_data(src_rd_data),
        .busy(busy), .done(done), .rd_idx(rd_idx), .rd_data(rd_data),
        .spr_sel(spr_sel), .spr_y(spr_y), .spr_tile(spr_tile),
        .spr_attr(spr_attr), .spr_x(spr_x)
    );

    function automatic logic [7:0] src_byte(input logic [15:0] a);
        return 8'(a[15:8] * 8'd13) + (a[7:0] ^ 8'hA5);
    endfunction

    // Source memory: one cycle of read latency, garbage when not strobed.
    always @(posedge clk) begin
        src_rd_data <= src_rd_en ? src_byte(src_addr) : 8'hEE;
    end

    // Read-stream monitor: counts strobes and address mismatches.
    int         mon_cnt = 0;
    int         mon_bad = 0;
    int         base_cnt = 0;
    logic [7:0] exp_page = 8'h00;
    always @(negedge clk) begin
        if (src_rd_en) begin
            if (src_addr !== {exp_page, 8'(mon_cnt - base_cnt)}) mon_bad <= mon_bad + 1;
            mon_cnt <= mon_cnt + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_store(input string req, input logic [7:0] page, input bit zero);
        int bad = 0;
        for (int i = 0; i < 256; i++) begin
            rd_idx = 8'(i);
            #0.01;
            if (rd_data !== (zero ? 8'h00 : src_byte({page, 8'(i)}))) bad++;
        end
        chk(req, bad, 0);
    endtask

    // Trigger page, optionally inject a second trigger mid-copy, wait for end.
    task automatic run_copy(input logic [7:0] page, input bit inject, input logic [7:0] other);
        int cyc = 0;
        int bad0;
        base_cnt = mon_cnt;
        bad0 = mon_bad;
        exp_page = page;
        @(negedge clk);
        trig_we = 1'b1; trig_page = page;
        @(negedge clk);
        trig_we = 1'b0;
        chk("R5 busy after trigger", busy, 1);
        while (busy && cyc < 400) begin
            cyc++;
            if (inject && cyc == 20) begin
                trig_we = 1'b1; trig_page = other;
            end else begin
                trig_we = 1'b0;
            end
            @(negedge clk);
        end
        trig_we = 1'b0;
        chk("R5 busy length", cyc, 257);
        chk("R6 done after busy", done, 1);
        chk("R3 strobe count", mon_cnt - base_cnt, 256);
        chk("R2 address stream", mon_bad - bad0, 0);
    endtask

    localparam logic [21:0] VEC_TAB [0:4] = '{
        {8'h00, 8'h00, 6'd0},
        {8'hFF, 8'hFF, 6'd63},
        {8'h02, 8'h41, 6'd17},
        {8'h7F, 8'h80, 6'd32},
        {8'hC3, 8'h3A, 6'd9}
    };

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // Reset state
        chk("R1 busy reset", busy, 0);
        chk("R1 done reset", done, 0);
        chk("R1 strobe reset", src_rd_en, 0);
        check_store("R1 store cleared", 8'h00, 1);

        // Table-driven copies
        foreach (VEC_TAB[v]) begin
            logic [7:0] pg, pb;
            logic [5:0] sp;
            {pg, pb, sp} = VEC_TAB[v];
            run_copy(pg, 0, 8'h00);
            @(negedge clk);
            chk("R6 done one cycle", done, 0);
            check_store("R4 store contents", pg, 0);
            rd_idx = pb; #0.01;
            chk("R9 byte port", rd_data, src_byte({pg, pb}));
            spr_sel = sp; #0.01;
            chk("R8 sprite y",    spr_y,    src_byte({pg, sp, 2'd0}));
            chk("R8 sprite tile", spr_tile, src_byte({pg, sp, 2'd1}));
            chk("R8 sprite attr", spr_attr, src_byte({pg, sp, 2'd2}));
            chk("R8 sprite x",    spr_x,    src_byte({pg, sp, 2'd3}));
        end

        // Trigger during busy is ignored (R7)
        run_copy(8'h35, 1, 8'h99);
        @(negedge clk);
        check_store("R7 ignored trigger contents", 8'h35, 0);

        // Trigger in the done cycle chains a new copy (R10)
        run_copy(8'h11, 0, 8'h00);
        base_cnt = mon_cnt;
        exp_page = 8'h22;
        trig_we = 1'b1; trig_page = 8'h22;
        @(negedge clk);
        trig_we = 1'b0;
        chk("R10 chained busy", busy, 1);
        chk("R10 chained no done", done, 0);
        while (busy) @(negedge clk);
        chk("R10 chained strobe count", mon_cnt - base_cnt, 256);
        @(negedge clk);
        check_store("R10 chained contents", 8'h22, 0);

        // Reset in the middle of a copy (R1)
        exp_page = 8'h44;
        base_cnt = mon_cnt;
        trig_we = 1'b1; trig_page = 8'h44;
        @(negedge clk);
        trig_we = 1'b0;
        repeat (50) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 abort busy", busy, 0);
        chk("R1 abort strobe", src_rd_en, 0);
        @(negedge clk);
        chk("R1 abort no done", done, 0);
        check_store("R1 abort store cleared", 8'h00, 1);

        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule